// File: doc/BRIEF.md
# Single-Wire Parity Chunk Transceiver

This block carries short chunks of data across one shared wire with a pull-up. A chunk holds from one to eight data bits. On the line a chunk looks like this: a low-then-high synchronisation pulse, the data bits with the most significant bit first, one even-parity bit, and then a low tail. The receiver locks onto the rising edge at the end of the synchronisation pulse. From that edge it samples each bit near the middle of its period. The frame has no start bit and no stop bit.

A transaction controller uses the block one chunk at a time. It raises `start` for one cycle and gives the direction, the chunk width and, when sending, the data. It then waits for the one-cycle `done` pulse. While sending, the block drives the line through `line_oe` and `line_out`. While receiving, it releases the line and samples `line_in` through a two-flop synchroniser. A parity mismatch does not abort reception. The data is still delivered, the `parity_err` flag is raised, and a saturating error counter is incremented.

The bit period is `BIT_CYC` clock cycles. For a 16 MHz clock the default of 96 gives 6 us per bit. The other usual periods (4, 12, 24, 36 and 48 us) are set through the same parameter. The high part of the synchronisation pulse lasts `SYNC_HI_CYC` cycles.

Top module: `swl_chunk_xcvr`

## Requirements
- R1: After reset the line is released (`line_oe`=0, `line_out`=1), `busy`, `done` and `parity_err` are 0, and `err_count` and `rx_data` are 0.
- R2: When a send starts, `line_oe` rises on the next edge. The line is then driven low for `BIT_CYC` cycles, then high for `SYNC_HI_CYC` cycles.
- R3: After the sync pulse, the low `nbits` bits of `tx_data` are sent, bit `nbits-1` first. Each bit is held for `BIT_CYC` cycles.
- R4: After the last data bit, a parity bit equal to the XOR of the sent data bits is held for `BIT_CYC` cycles.
- R5: After the parity bit, the line is driven low and stays driven low until the next command. `done` pulses for one cycle on the edge that starts the tail, and `busy` falls on that same edge.
- R6: During a receive the line is released from the edge after `start` until `done`. The receiver waits while the line is high, then waits while it is low. It takes the rising edge as its reference and samples the first bit `SYNC_HI_CYC + BIT_CYC/2` cycles after it, then every `BIT_CYC` cycles. `rx_data` holds the bits right-aligned, with the first received bit the most significant and the unused upper bits 0.
- R7: If the received parity bit differs from the XOR of the received data bits, `parity_err` is 1 when `done` pulses, the data is still delivered, and `err_count` rises by one, saturating. `parity_err` is cleared by the next accepted `start`.
- R8: If the line stays high for `TMO_PERIODS*BIT_CYC` cycles after a receive starts, that moment is taken as the reference. `done` then follows exactly `SYNC_HI_CYC + BIT_CYC/2 + nbits*BIT_CYC` cycles later.
- R9: A `start` with `nbits`=0 gives `done` on the next edge with `busy` staying 0 and `parity_err` 0, and leaves `line_oe` and `line_out` unchanged.
- R10: `nbits` is latched at `start`. Values above 8 act as 8, and changes to `nbits` during a chunk have no effect.
- R11: A `start` while `busy` is 1 is ignored, so the chunk in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chunk (ignored while busy) |
| dir_tx | input | 1 | 1 = send, 0 = receive |
| nbits | input | 4 | Chunk width, 0..8 (larger acts as 8) |
| tx_data | input | 8 | Data to send, right-aligned |
| line_in | input | 1 | Sampled wire level |
| line_oe | output | 1 | Drive enable for the wire |
| line_out | output | 1 | Level driven when enabled |
| busy | output | 1 | Chunk in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last received chunk, right-aligned |
| parity_err | output | 1 | Parity mismatch on the last receive |
| err_count | output | 8 | Saturating count of parity mismatches |

## Verification
The hardest case to reach is the receive timeout. The line must stay high with no sync pulse, so that the receiver falls back to using the timeout as its reference and samples a floating-high line. The bench gets there by starting a receive while its own line model stays released. It then checks the exact completion cycle, the all-ones data and the parity result for both an even and an odd chunk width. A second hard case is a `start` pulse or an `nbits` change that lands in the middle of a chunk. The bench injects both during live frames and compares every line cycle against its own frame model.

// File: rtl/swl_pkg.sv
package swl_pkg;

    localparam int MAX_BITS = 8;
    localparam int BITS_W   = $clog2(MAX_BITS + 1);

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SYNC_LO,
        TX_SYNC_HI,
        TX_DATA,
        TX_PAR
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_WAIT_HI,
        RX_WAIT_LO,
        RX_SAMPLE
    } rx_state_e;

    typedef struct packed {
        logic [BITS_W-1:0]   nbits;
        logic [MAX_BITS-1:0] shreg;
        logic                par;
    } tx_job_t;

    function automatic logic [BITS_W-1:0] clamp_bits(input logic [BITS_W-1:0] n);
        return (n > BITS_W'(MAX_BITS)) ? BITS_W'(MAX_BITS) : n;
    endfunction

    function automatic logic even_parity(input logic [MAX_BITS-1:0] d,
                                         input logic [BITS_W-1:0]   n);
        logic p;
        p = 1'b0;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (i < int'(n)) p = p ^ d[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/swl_sync.sv
module swl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/swl_tx.sv
module swl_tx
    import swl_pkg::*;
#(
    parameter int BIT_CYC     = 96,
    parameter int SYNC_HI_CYC = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                release_line,
    input  logic [BITS_W-1:0]   nbits_c,
    input  logic [MAX_BITS-1:0] data,
    output logic                oe,
    output logic                out,
    output logic                busy,
    output logic                done
);
    localparam int CW = $clog2(BIT_CYC + SYNC_HI_CYC + 1);

    tx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [BITS_W-1:0] left;
    tx_job_t           job;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            cnt   <= '0;
            left  <= '0;
            job   <= '0;
            oe    <= 1'b0;
            out   <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (go) begin
                        job.nbits <= nbits_c;
                        job.shreg <= data << (BITS_W'(MAX_BITS) - nbits_c);
                        job.par   <= even_parity(data, nbits_c);
                        oe        <= 1'b1;
                        out       <= 1'b0;
                        cnt       <= CW'(BIT_CYC - 1);
                        state     <= TX_SYNC_LO;
                    end else if (release_line) begin
                        oe  <= 1'b0;
                        out <= 1'b1;
                    end
                end
                TX_SYNC_LO: begin
                    if (cnt == '0) begin
                        out   <= 1'b1;
                        cnt   <= CW'(SYNC_HI_CYC - 1);
                        state <= TX_SYNC_HI;
                    end else cnt <= cnt - 1'b1;
                end
                TX_SYNC_HI: begin
                    if (cnt == '0) begin
                        out       <= job.shreg[MAX_BITS-1];
                        job.shreg <= job.shreg << 1;
                        left      <= job.nbits - 1'b1;
                        cnt       <= CW'(BIT_CYC - 1);
                        state     <= TX_DATA;
                    end else cnt <= cnt - 1'b1;
                end
                TX_DATA: begin
                    if (cnt == '0) begin
                        cnt <= CW'(BIT_CYC - 1);
                        if (left == '0) begin
                            out   <= job.par;
                            state <= TX_PAR;
                        end else begin
                            out       <= job.shreg[MAX_BITS-1];
                            job.shreg <= job.shreg << 1;
                            left      <= left - 1'b1;
                        end
                    end else cnt <= cnt - 1'b1;
                end
                TX_PAR: begin
                    if (cnt == '0) begin
                        out   <= 1'b0;
                        done  <= 1'b1;
                        state <= TX_IDLE;
                    end else cnt <= cnt - 1'b1;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign busy = (state != TX_IDLE);

    // R2
    sync_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_SYNC_LO) |-> (oe && !out));

    // R5
    tail_low_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (oe && !out) || busy || !oe);
endmodule

// File: rtl/swl_rx.sv
module swl_rx
    import swl_pkg::*;
#(
    parameter int BIT_CYC     = 96,
    parameter int SYNC_HI_CYC = 2,
    parameter int TMO_PERIODS = 5,
    parameter int ERR_W       = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                clr,
    input  logic [BITS_W-1:0]   nbits_c,
    input  logic                s_line,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] data,
    output logic                perr,
    output logic [ERR_W-1:0]    err_cnt
);
    localparam int TMO_CYC   = TMO_PERIODS * BIT_CYC;
    localparam int FIRST_CYC = SYNC_HI_CYC + BIT_CYC / 2;
    localparam int RW        = $clog2(TMO_CYC + FIRST_CYC + BIT_CYC + 1);

    rx_state_e           state;
    logic [RW-1:0]       cnt;
    logic [BITS_W-1:0]   nb;
    logic [BITS_W-1:0]   idx;
    logic [MAX_BITS-1:0] shreg;
    logic                par;
    logic                mismatch;

    assign mismatch = par ^ s_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            nb      <= '0;
            idx     <= '0;
            shreg   <= '0;
            par     <= 1'b0;
            done    <= 1'b0;
            data    <= '0;
            perr    <= 1'b0;
            err_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (clr) perr <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (go) begin
                        nb    <= nbits_c;
                        idx   <= '0;
                        shreg <= '0;
                        par   <= 1'b0;
                        cnt   <= '0;
                        state <= RX_WAIT_HI;
                    end
                end
                RX_WAIT_HI: begin
                    if (!s_line) begin
                        state <= RX_WAIT_LO;
                    end else if (cnt == RW'(TMO_CYC - 1)) begin
                        cnt   <= RW'(FIRST_CYC - 1);
                        state <= RX_SAMPLE;
                    end else cnt <= cnt + 1'b1;
                end
                RX_WAIT_LO: begin
                    if (s_line) begin
                        cnt   <= RW'(FIRST_CYC - 1);
                        state <= RX_SAMPLE;
                    end
                end
                RX_SAMPLE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (idx == nb) begin
                        data  <= shreg;
                        perr  <= mismatch;
                        done  <= 1'b1;
                        state <= RX_IDLE;
                        if (mismatch && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
                    end else begin
                        shreg <= {shreg[MAX_BITS-2:0], s_line};
                        par   <= par ^ s_line;
                        idx   <= idx + 1'b1;
                        cnt   <= RW'(BIT_CYC - 1);
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign busy = (state != RX_IDLE);

    // R10
    width_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_SAMPLE) |-> (idx <= nb && nb <= BITS_W'(MAX_BITS)));

    // R7
    err_step_chk: assert property (@(posedge clk) disable iff (rst)
        (done && perr && $past(err_cnt) != '1) |-> (err_cnt == $past(err_cnt) + 1'b1));

    // R7
    err_mono_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (err_cnt >= $past(err_cnt)));
endmodule

// File: rtl/swl_chunk_xcvr.sv
module swl_chunk_xcvr
    import swl_pkg::*;
#(
    parameter int BIT_CYC     = 96,
    parameter int SYNC_HI_CYC = 2,
    parameter int TMO_PERIODS = 5,
    parameter int SYNC_STAGES = 2,
    parameter int ERR_W       = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                dir_tx,
    input  logic [BITS_W-1:0]   nbits,
    input  logic [MAX_BITS-1:0] tx_data,
    input  logic                line_in,
    output logic                line_oe,
    output logic                line_out,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                parity_err,
    output logic [ERR_W-1:0]    err_count
);
    logic [BITS_W-1:0] nb_c;
    logic accept, go_tx, go_rx, zero_len;
    logic tx_busy, tx_done, rx_busy, rx_done, s_line;
    logic zero_done;

    assign nb_c     = clamp_bits(nbits);
    assign accept   = start && !busy;
    assign zero_len = accept && (nb_c == '0);
    assign go_tx    = accept && dir_tx && (nb_c != '0);
    assign go_rx    = accept && !dir_tx && (nb_c != '0);

    swl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (s_line)
    );

    swl_tx #(.BIT_CYC(BIT_CYC), .SYNC_HI_CYC(SYNC_HI_CYC)) u_tx (
        .clk          (clk),
        .rst          (rst),
        .go           (go_tx),
        .release_line (go_rx),
        .nbits_c      (nb_c),
        .data         (tx_data),
        .oe           (line_oe),
        .out          (line_out),
        .busy         (tx_busy),
        .done         (tx_done)
    );

    swl_rx #(
        .BIT_CYC     (BIT_CYC),
        .SYNC_HI_CYC (SYNC_HI_CYC),
        .TMO_PERIODS (TMO_PERIODS),
        .ERR_W       (ERR_W)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .go      (go_rx),
        .clr     (accept),
        .nbits_c (nb_c),
        .s_line  (s_line),
        .busy    (rx_busy),
        .done    (rx_done),
        .data    (rx_data),
        .perr    (parity_err),
        .err_cnt (err_count)
    );

    always_ff @(posedge clk) begin
        if (rst) zero_done <= 1'b0;
        else     zero_done <= zero_len;
    end

    assign busy = tx_busy || rx_busy;
    assign done = tx_done || rx_done || zero_done;

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R6
    rx_release_chk: assert property (@(posedge clk) disable iff (rst)
        rx_busy |-> !line_oe);

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && nbits == '0) |=> (done && !busy && !parity_err
                                              && $stable(line_oe) && $stable(line_out)));

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (busy || done));
endmodule

// File: tb/swl_chunk_xcvr_tb.sv
module swl_chunk_xcvr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BIT        = 16;
    localparam int HI         = 2;
    localparam int TMO_P      = 5;
    localparam int TMO        = TMO_P * BIT;

    localparam logic [1:0] K_TX = 2'd0, K_RX = 2'd1, K_ZERO = 2'd2;

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] data;
        logic       perr;
        logic       oe;
        logic       out;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, dir_tx = 1'b0;
    logic [3:0] nbits = '0;
    logic [7:0] tx_data = '0;
    logic b_oe = 1'b0, b_out = 1'b1;
    logic line_w;
    logic line_oe, line_out, busy, done, parity_err;
    logic [7:0] rx_data, err_count;

    int n_chk = 0, n_fail = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_w = line_oe ? line_out : (b_oe ? b_out : 1'b1);

    swl_chunk_xcvr #(.BIT_CYC(BIT), .SYNC_HI_CYC(HI), .TMO_PERIODS(TMO_P)) u_dut (
        .clk(clk), .rst(rst), .start(start), .dir_tx(dir_tx), .nbits(nbits),
        .tx_data(tx_data), .line_in(line_w), .line_oe(line_oe), .line_out(line_out),
        .busy(busy), .done(done), .rx_data(rx_data), .parity_err(parity_err),
        .err_count(err_count)
    );

    task automatic check(input bit ok, input string req, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "done with no expected item (actual done=1, expected 0)");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.kind == K_RX) begin
                    check(rx_data === e.data, "R6",
                          $sformatf("rx_data actual %h expected %h", rx_data, e.data));
                    check(parity_err === e.perr, "R7",
                          $sformatf("parity_err actual %b expected %b", parity_err, e.perr));
                end else begin
                    check(line_oe === e.oe && line_out === e.out,
                          (e.kind == K_TX) ? "R5" : "R9",
                          $sformatf("line oe/out actual %b/%b expected %b/%b",
                                    line_oe, line_out, e.oe, e.out));
                    if (e.kind == K_ZERO)
                        check(parity_err === 1'b0, "R9",
                              $sformatf("parity_err actual %b expected 0", parity_err));
                end
            end
        end
    end

    task automatic send_chunk(input logic [3:0] n, input logic [7:0] d, input bit poke);
        int ne, total;
        logic par;
        bit bad [2:5];
        ne = (n > 8) ? 8 : int'(n);
        par = 1'b0;
        for (int i = 0; i < ne; i++) par ^= d[i];
        total = BIT + HI + (ne + 1) * BIT;
        for (int p = 2; p <= 5; p++) bad[p] = 1'b0;
        exp_q.push_back('{kind: K_TX, data: 8'h00, perr: 1'b0, oe: 1'b1, out: 1'b0});
        @(negedge clk); start = 1'b1; dir_tx = 1'b1; nbits = n; tx_data = d;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c <= total; c++) begin
            logic eo;
            int ph, k;
            string rq;
            if (c < BIT) begin eo = 1'b0; ph = 2; end
            else if (c < BIT + HI) begin eo = 1'b1; ph = 2; end
            else begin
                k = (c - BIT - HI) / BIT;
                if (k < ne) begin eo = d[ne-1-k]; ph = 3; end
                else if (k == ne) begin eo = par; ph = 4; end
                else begin eo = 1'b0; ph = 5; end
            end
            if (c == total) ph = 5;
            case (ph)
                2: rq = "R2";
                3: rq = "R3";
                4: rq = "R4";
                default: rq = "R5";
            endcase
            if (line_w !== eo || line_oe !== 1'b1 || busy !== (c != total)
                || done !== (c == total)) begin
                if (!bad[ph]) $display("FAIL %s: tx cycle %0d line/oe/busy/done actual %b/%b/%b/%b expected %b/1/%b/%b",
                                       rq, c, line_w, line_oe, busy, done, eo, (c != total), (c == total));
                bad[ph] = 1'b1;
            end
            // R11 / R10: start pulse and width change during a live frame
            if (poke && c == BIT + 3) begin start = 1'b1; tx_data = ~d; nbits = 4'd1; end
            if (poke && c == BIT + 4) start = 1'b0;
            @(negedge clk);
        end
        for (int p = 2; p <= 5; p++) begin
            n_chk++;
            if (bad[p]) n_fail++;
        end
    endtask

    task automatic recv_chunk(input logic [3:0] n, input logic [7:0] d, input bit badp,
                              input bit chg_n);
        int ne, c;
        logic par;
        logic [7:0] mask;
        bit oe_bad, fin;
        ne = (n > 8) ? 8 : int'(n);
        mask = (ne == 8) ? 8'hFF : 8'((1 << ne) - 1);
        par = 1'b0;
        for (int i = 0; i < ne; i++) par ^= d[i];
        exp_q.push_back('{kind: K_RX, data: d & mask, perr: badp, oe: 1'b0, out: 1'b1});
        @(negedge clk); start = 1'b1; dir_tx = 1'b0; nbits = n;
        @(negedge clk); start = 1'b0;
        oe_bad = 1'b0; fin = 1'b0;
        for (c = 0; c < 600 && !fin; c++) begin
            int k;
            b_oe = 1'b1;
            if (c < BIT) b_out = 1'b0;
            else if (c < BIT + HI) b_out = 1'b1;
            else begin
                k = (c - BIT - HI) / BIT;
                if (k < ne) b_out = d[ne-1-k];
                else if (k == ne) b_out = par ^ badp;
                else b_out = 1'b0;
            end
            if (chg_n && c == 2 * BIT) nbits = 4'd2;
            if (line_oe !== 1'b0) oe_bad = 1'b1;
            if (c > 0 && busy === 1'b0) fin = 1'b1;
            if (!fin) @(negedge clk);
        end
        check(!oe_bad, "R6", $sformatf("line_oe during receive actual 1 expected 0"));
        check(fin, "R6", $sformatf("receive done actual %b expected 1", fin));
        @(negedge clk); b_oe = 1'b0; b_out = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic recv_timeout(input logic [3:0] n);
        int ne, c, exp_c;
        logic [7:0] mask;
        ne = int'(n);
        mask = (ne == 8) ? 8'hFF : 8'((1 << ne) - 1);
        exp_c = TMO + HI + BIT / 2 + ne * BIT;
        exp_q.push_back('{kind: K_RX, data: mask, perr: !ne[0], oe: 1'b0, out: 1'b1});
        @(negedge clk); start = 1'b1; dir_tx = 1'b0; nbits = n;
        @(negedge clk); start = 1'b0;
        for (c = 0; c < 1000; c++) begin
            if (c > 0 && busy === 1'b0) break;
            @(negedge clk);
        end
        check(c == exp_c, "R8", $sformatf("timeout done cycle actual %0d expected %0d", c, exp_c));
        repeat (3) @(negedge clk);
    endtask

    task automatic zero_chunk();
        logic o_oe, o_out;
        o_oe = line_oe; o_out = line_out;
        exp_q.push_back('{kind: K_ZERO, data: 8'h00, perr: 1'b0, oe: o_oe, out: o_out});
        @(negedge clk); start = 1'b1; nbits = 4'd0;
        @(negedge clk); start = 1'b0;
        check(done === 1'b1 && busy === 1'b0, "R9",
              $sformatf("zero width done/busy actual %b/%b expected 1/0", done, busy));
        @(negedge clk);
        check(done === 1'b0 && line_oe === o_oe && line_out === o_out, "R9",
              $sformatf("after zero width done/oe/out actual %b/%b/%b expected 0/%b/%b",
                        done, line_oe, line_out, o_oe, o_out));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "R5", "watchdog expired (actual hung, expected completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R1 reset state
        check(line_oe === 1'b0 && line_out === 1'b1 && busy === 1'b0 && done === 1'b0
              && err_count === 8'd0 && rx_data === 8'd0 && parity_err === 1'b0, "R1",
              $sformatf("reset oe/out/busy/done/err/rx actual %b/%b/%b/%b/%h/%h expected 0/1/0/0/00/00",
                        line_oe, line_out, busy, done, err_count, rx_data));
        rst = 1'b0;
        repeat (2) @(negedge clk);

        send_chunk(4'd8, 8'hA5, 1'b0);
        send_chunk(4'd5, 8'h13, 1'b0);
        send_chunk(4'd1, 8'h01, 1'b0);
        send_chunk(4'd12, 8'h3C, 1'b1);   // R10 clamp, R11 start during busy
        send_chunk(4'd8, 8'hFF, 1'b0);
        zero_chunk();                     // R9 while still driving the tail

        recv_chunk(4'd8, 8'h5A, 1'b0, 1'b0);
        recv_chunk(4'd3, 8'h05, 1'b1, 1'b0);   // R7 bad parity
        check(err_count === 8'd1, "R7", $sformatf("err_count actual %0d expected 1", err_count));
        recv_chunk(4'd8, 8'h00, 1'b0, 1'b0);
        recv_chunk(4'd9, 8'hC3, 1'b0, 1'b0);   // R10 width above 8
        recv_chunk(4'd6, 8'h2D, 1'b0, 1'b1);   // R10 width change mid-chunk

        recv_timeout(4'd8);                    // R8 even-ones data, parity mismatch
        recv_timeout(4'd3);                    // R8 odd-ones data, parity matches
        zero_chunk();                          // R9 with the line released

        check(err_count === 8'd2, "R7", $sformatf("final err_count actual %0d expected 2", err_count));
        check(exp_q.size() == 0, "R5", $sformatf("pending items actual %0d expected 0", exp_q.size()));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule